// File: doc/BRIEF.md
# Vectored Interrupt Priority Generator

This block collects maskable interrupt requests from up to fourteen on-chip sources and one off-chip requester on the expansion bus. It keeps one pending flag for each on-chip source and raises a single request line to the processor. During the processor's interrupt acknowledge cycle it returns a vector byte that names the winning source. A one-cycle raise strobe sets a source's flag. An acknowledge clears the flag of the source whose code went out, and no other flag.

A small control register sets how the block behaves. Its upper three bits become the top of every vector. Its lowest bit picks between a plain pulse mode and the vectored mode. Another bit is an enable flag that the block stores and drives out to the rest of the chip. On-chip sources are ranked by index, and index 0 has the highest priority. The expansion bus ranks below all of them and may place its own vector on the bus. Once an acknowledge starts, the vector is frozen until the acknowledge ends.

Top module: `irq_vec_gen`

## Requirements
- R1: After reset, the control register reads 0x00, `int_req` is low, `aux_en` is low and `vec_out` is 0xFF.
- R2: A control write stores bits 7:5, bit 3 and bit 0. Bits 4, 2 and 1 always read 0, so a write of 0xFF reads back as 0xE9.
- R3: In vectored mode (control bit 0 = 1) with an on-chip source pending, `vec_out` = {control[7:5], 4-bit source code, 1'b0}, and the source code equals the source index.
- R4: When several on-chip sources are pending, the lowest index wins. Acknowledging them one at a time returns codes 0, 1, 2 … 13 in that order.
- R5: The expansion bus wins only when no on-chip source is pending. `vec_out` is then `ext_vec` when `ext_vec_valid` is high, and 0xFF when it is low.
- R6: In pulse mode (control bit 0 = 0), `vec_out` is 0xFF while `int_req` still follows the pending sources and `ext_req`.
- R7: The vector shown in the first cycle of an acknowledge stays unchanged until `inta` falls, even if new requests arrive or the control register is written during the cycle.
- R8: The rising edge of `inta` clears only the pending flag of the on-chip source whose code was issued. When the expansion bus wins, no flag is cleared.
- R9: A raise strobe for a source in the same cycle as its clear leaves that source pending.
- R10: `aux_en` follows control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register read data |
| src_raise | input | NUM_SRC | One-cycle raise strobes, bit i sets the flag of source i |
| ext_req | input | 1 | Expansion bus interrupt request (level) |
| ext_vec_valid | input | 1 | Expansion bus supplies a vector |
| ext_vec | input | 8 | Expansion bus vector byte |
| inta | input | 1 | Interrupt acknowledge, high for the whole cycle |
| int_req | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector byte for the acknowledge cycle |
| aux_en | output | 1 | Stored enable flag (control bit 3) |

## Verification
A flag that was not set or was cleared by mistake shows up at the next acknowledge: the returned code skips a number or repeats one. A full priority sweep therefore exposes it within a single acknowledge. A freeze register that fails to load, or reloads, changes `vec_out` in the second cycle of `inta`. A broken arbitration path shows up at once in `vec_out` in the cycle after the raise strobe.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

   localparam int VEC_W  = 8;
   localparam int HI_W   = 3;
   localparam logic [VEC_W-1:0] VEC_NONE = 8'hFF;

   typedef struct packed {
      logic [HI_W-1:0] vec_hi;
      logic            aux_en;
      logic            vec_mode;
   } irq_ctrl_t;

   function automatic logic [VEC_W-1:0] ctrl_to_byte(irq_ctrl_t c);
      return {c.vec_hi, 1'b0, c.aux_en, 2'b00, c.vec_mode};
   endfunction

   function automatic irq_ctrl_t byte_to_ctrl(logic [VEC_W-1:0] b);
      irq_ctrl_t c;
      c.vec_hi   = b[7:5];
      c.aux_en   = b[3];
      c.vec_mode = b[0];
      return c;
   endfunction

endpackage

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
   import irq_vec_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [VEC_W-1:0] wdata,
   output irq_ctrl_t        ctrl,
   output logic [VEC_W-1:0] rdata
);

   irq_ctrl_t ctrl_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (we)
         ctrl_q <= byte_to_ctrl(wdata);
   end

   assign ctrl  = ctrl_q;
   assign rdata = ctrl_to_byte(ctrl_q);

endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
   parameter int NUM_SRC = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] raise,
   input  logic [NUM_SRC-1:0] clr,
   output logic [NUM_SRC-1:0] pending
);

   logic [NUM_SRC-1:0] pend_q;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)
            pend_q[i] <= 1'b0;
         else if (raise[i])
            pend_q[i] <= 1'b1;
         else if (clr[i])
            pend_q[i] <= 1'b0;
      end
   end

   assign pending = pend_q;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int NUM_SRC = 14,
   parameter int CODE_W  = 4
) (
   input  logic [NUM_SRC-1:0] req,
   output logic               any,
   output logic [CODE_W-1:0]  code,
   output logic [NUM_SRC-1:0] grant
);

   always_comb begin
      code  = '0;
      grant = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (req[i]) begin
            code  = CODE_W'(i);
            grant = '0;
            grant[i] = 1'b1;
         end
      end
   end

   assign any = |req;

endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen
   import irq_vec_pkg::*;
#(
   parameter int NUM_SRC = 14,
   parameter int CODE_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctrl_we,
   input  logic [7:0]         ctrl_wdata,
   output logic [7:0]         ctrl_rdata,
   input  logic [NUM_SRC-1:0] src_raise,
   input  logic               ext_req,
   input  logic               ext_vec_valid,
   input  logic [7:0]         ext_vec,
   input  logic               inta,
   output logic               int_req,
   output logic [7:0]         vec_out,
   output logic               aux_en
);

   localparam int MAX_SRC = 2 ** CODE_W;

   if (CODE_W != VEC_W - HI_W - 1) begin : g_bad_code_w
      $error("irq_vec_gen: CODE_W must fill vector bits 4:1");
   end
   if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_num_src
      $error("irq_vec_gen: NUM_SRC out of range for CODE_W");
   end

   irq_ctrl_t          ctrl_q;
   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] clr_mask;
   logic [NUM_SRC-1:0] win_grant;
   logic [CODE_W-1:0]  win_code;
   logic               any_int;
   logic               mode_on;
   logic               inta_q;
   logic               ack_start;
   logic [VEC_W-1:0]   live_vec;
   logic [VEC_W-1:0]   frozen_vec;

   irq_ctrl_reg u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ctrl_we),
      .wdata (ctrl_wdata),
      .ctrl  (ctrl_q),
      .rdata (ctrl_rdata)
   );

   irq_pending #(.NUM_SRC(NUM_SRC)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .raise   (src_raise),
      .clr     (clr_mask),
      .pending (pend_q)
   );

   irq_prio_enc #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_enc (
      .req   (pend_q),
      .any   (any_int),
      .code  (win_code),
      .grant (win_grant)
   );

   assign mode_on   = ctrl_q.vec_mode;
   assign ack_start = inta && !inta_q;
   assign clr_mask  = ack_start ? win_grant : '0;

   always_comb begin
      if (!mode_on)
         live_vec = VEC_NONE;
      else if (any_int)
         live_vec = {ctrl_q.vec_hi, win_code, 1'b0};
      else if (ext_req && ext_vec_valid)
         live_vec = ext_vec;
      else
         live_vec = VEC_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inta_q     <= 1'b0;
         frozen_vec <= VEC_NONE;
      end else begin
         inta_q <= inta;
         if (ack_start)
            frozen_vec <= live_vec;
      end
   end

   assign vec_out = (inta && inta_q) ? frozen_vec : live_vec;
   assign int_req = any_int || ext_req;
   assign aux_en  = ctrl_q.aux_en;

endmodule

// File: rtl/irq_vec_gen_chk.sv
module irq_vec_gen_chk #(
   parameter int NUM_SRC = 14
) (
   input logic               clk,
   input logic               rst_n,
   input logic               inta,
   input logic               int_req,
   input logic [7:0]         vec_out,
   input logic               mode_on,
   input logic               any_int,
   input logic [NUM_SRC-1:0] pending
);

   // R6
   pulse_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_on |-> vec_out == 8'hFF);

   // R3
   vec_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_on && any_int && !inta) |-> vec_out[0] == 1'b0);

   // R7
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && $past(inta)) |-> vec_out == $past(vec_out));

   // R8
   single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> $countones($past(pending) & ~pending) <= 1);

   // R1
   idle_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_req && !inta) |-> vec_out == 8'hFF);

endmodule

bind irq_vec_gen irq_vec_gen_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .inta    (inta),
   .int_req (int_req),
   .vec_out (vec_out),
   .mode_on (mode_on),
   .any_int (any_int),
   .pending (pend_q)
);

// File: tb/irq_vec_gen_bench.sv
`timescale 1ns/1ps
module irq_vec_gen_bench;

   localparam int NS = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctrl_we = 1'b0;
   logic [7:0]    ctrl_wdata = '0;
   logic [7:0]    ctrl_rdata;
   logic [NS-1:0] src_raise = '0;
   logic          ext_req = 1'b0;
   logic          ext_vec_valid = 1'b0;
   logic [7:0]    ext_vec = '0;
   logic          inta = 1'b0;
   logic          int_req;
   logic [7:0]    vec_out;
   logic          aux_en;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   irq_vec_gen #(.NUM_SRC(NS), .CODE_W(4)) u_irq_vec_gen (
      .clk, .rst_n, .ctrl_we, .ctrl_wdata, .ctrl_rdata, .src_raise,
      .ext_req, .ext_vec_valid, .ext_vec, .inta, .int_req, .vec_out, .aux_en
   );

   function automatic logic [7:0] vexp(logic [2:0] hi, int code);
      return {hi, 4'(code), 1'b0};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr_ctrl(logic [7:0] d);
      @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = d;
      @(negedge clk); ctrl_we = 1'b0;
      #1;
   endtask

   task automatic raise(logic [NS-1:0] m);
      @(negedge clk); src_raise = m;
      @(negedge clk); src_raise = '0;
      #1;
   endtask

   // v1: first acknowledge cycle, v2: second cycle (frozen value)
   task automatic ack(output logic [7:0] v1, output logic [7:0] v2);
      @(negedge clk); inta = 1'b1; #1; v1 = vec_out;
      @(negedge clk); #1; v2 = vec_out;
      @(negedge clk); inta = 1'b0; #1;
   endtask

   task automatic t_reset;
      check("R1 ctrl", ctrl_rdata, 8'h00);
      check("R1 int_req", int_req, 1'b0);
      check("R1 aux_en", aux_en, 1'b0);
      check("R1 vec", vec_out, 8'hFF);
   endtask

   task automatic t_ctrl;
      wr_ctrl(8'hFF);
      check("R2 readback ff", ctrl_rdata, 8'hE9);
      check("R10 aux on", aux_en, 1'b1);
      wr_ctrl(8'h16);
      check("R2 reserved", ctrl_rdata, 8'h00);
      check("R10 aux off", aux_en, 1'b0);
   endtask

   task automatic t_each;
      logic [7:0] a, b;
      wr_ctrl(8'hA1);
      for (int i = 0; i < NS; i++) begin
         raise(NS'(1) << i);
         check("R3 vec", vec_out, vexp(3'b101, i));
         ack(a, b);
         check("R3 ack vec", b, vexp(3'b101, i));
         check("R8 cleared", int_req, 1'b0);
      end
   endtask

   task automatic t_prio;
      logic [7:0] a, b;
      wr_ctrl(8'h61);
      raise('1);
      for (int i = 0; i < NS; i++) begin
         check("R4 req", int_req, 1'b1);
         ack(a, b);
         check("R4 order", a, vexp(3'b011, i));
         check("R8 one cleared", vec_out, (i == NS - 1) ? 8'hFF : vexp(3'b011, i + 1));
      end
   endtask

   task automatic t_ext;
      logic [7:0] a, b;
      wr_ctrl(8'h01);
      @(negedge clk); ext_req = 1'b1; ext_vec_valid = 1'b1; ext_vec = 8'h3C; #1;
      check("R5 ext vec", vec_out, 8'h3C);
      check("R5 ext req", int_req, 1'b1);
      ext_vec_valid = 1'b0; #1;
      check("R5 no vec", vec_out, 8'hFF);
      ext_vec_valid = 1'b1;
      raise(NS'(1) << 13);
      check("R5 internal wins", vec_out, vexp(3'b000, 13));
      ack(a, b);
      check("R5 back to ext", vec_out, 8'h3C);
      ack(a, b);
      check("R8 ext ack", b, 8'h3C);
      check("R8 ext no clear", int_req, 1'b1);
      @(negedge clk); ext_req = 1'b0; ext_vec_valid = 1'b0; #1;
      check("R5 idle", int_req, 1'b0);
   endtask

   task automatic t_pulse;
      logic [7:0] a, b;
      wr_ctrl(8'hE0);
      raise(NS'(1) << 2);
      check("R6 req", int_req, 1'b1);
      check("R6 vec", vec_out, 8'hFF);
      ack(a, b);
      check("R6 ack vec", a, 8'hFF);
      check("R6 cleared", int_req, 1'b0);
   endtask

   task automatic t_freeze;
      logic [7:0] b;
      wr_ctrl(8'h41);
      raise(NS'(1) << 5);
      @(negedge clk); inta = 1'b1; #1;
      check("R7 first", vec_out, vexp(3'b010, 5));
      @(negedge clk); src_raise = NS'(1); ctrl_we = 1'b1; ctrl_wdata = 8'hE1; #1;
      check("R7 hold a", vec_out, vexp(3'b010, 5));
      @(negedge clk); src_raise = '0; ctrl_we = 1'b0; #1;
      check("R7 hold b", vec_out, vexp(3'b010, 5));
      @(negedge clk); inta = 1'b0; #1;
      check("R7 release", vec_out, vexp(3'b111, 0));
      ack(b, b);
      check("R8 five gone", int_req, 1'b0);
   endtask

   task automatic t_race;
      logic [7:0] b;
      wr_ctrl(8'h21);
      raise(NS'(1) << 7);
      @(negedge clk); inta = 1'b1; src_raise = NS'(1) << 7;
      @(negedge clk); src_raise = '0;
      @(negedge clk); inta = 1'b0; #1;
      check("R9 still pending", int_req, 1'b1);
      check("R9 vec", vec_out, vexp(3'b001, 7));
      ack(b, b);
      check("R9 cleared later", int_req, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_ctrl();
      t_each();
      t_prio();
      t_ext();
      t_pulse();
      t_freeze();
      t_race();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule